// File: doc/BRIEF.md
# Round-Robin ADC Sample Sequencer

This block shares one analog-to-digital converter among four motor-controller channels. It visits the channels one after another in a fixed cycle. For the channel it is visiting, it drives a 2-bit channel index and that channel's floating-phase code, so the converter front end can pick the right analog input. It then waits until the channel is allowed to sample, sends a single start-of-conversion pulse, and waits for the converter to report completion. On completion it raises a result strobe for that channel only, together with the timestamp it captured when the conversion started.

Each channel has a sample-enable flag, and the sequencer does not start a conversion on a channel whose flag is low. Each channel also has a PWM input. Any transition of that input, rising or falling, restarts a blanking window whose length in clock cycles is programmable, and no conversion may start on the channel while the window is open. A per-channel extra-blank input holds sampling off for reasons other than PWM switching. Each channel has its own free-running timestamp counter, and the start of each conversion freezes that counter's value for the result.

Top module: `adc_rr_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it is released, `ch_sel` is 0, `soc` is low and `result_valid` is all zeros.
- R2: `ch_sel` changes only by stepping to the next index modulo 4. The order is 0, 1, 2, 3, 0.
- R3: A channel whose `samp_en` bit is low gets no conversion in its turn. When all four enable bits are low, `soc` stays low.
- R4: A transition in either direction on `pwm[i]` restarts the blanking window of channel i. If the sequencer is waiting on channel i, `soc` rises exactly `blank_cycles`+2 cycles after the cycle in which the last transition is seen.
- R5: While `extra_blank[i]` is high, no conversion starts on channel i. When it falls and no PWM window is open, `soc` rises in the next cycle.
- R6: If a channel's enable is dropped while the sequencer is waiting for its blanking to end, the sequencer moves on without converting it.
- R7: `soc` is high for exactly one cycle. It is raised only when, in the previous cycle, the selected channel was enabled and not blanked.
- R8: `phase_out` carries the 2-bit phase code (`phase_sel[2i+1:2i]`) of the selected channel. An out-of-range code of 3 is sent as 0.
- R9: `result_valid` is one-hot, with the bit of the selected channel set, in the cycle in which `conv_done` is high while a conversion is outstanding. At any other time `conv_done` is ignored.
- R10: Every channel's timestamp counter is 0 in the cycle after reset and then increases by 1 per clock. `result_ts` equals the value that the selected channel's counter had in the `soc` cycle.
- R11: From reset with a given enable mask, the enabled channels are converted in ascending cyclic order. No enabled channel waits more than four conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blank_cycles | input | BLANK_W | Blanking window length in clock cycles |
| pwm | input | 4 | PWM signal of each channel |
| samp_en | input | 4 | Sample enable of each channel |
| extra_blank | input | 4 | Extra blanking request of each channel |
| phase_sel | input | 8 | 2-bit floating-phase code of each channel, with channel i in bits 2i+1:2i |
| conv_done | input | 1 | Conversion-complete pulse from the converter |
| ch_sel | output | 2 | Index of the channel being visited |
| phase_out | output | 2 | Phase code sent with the conversion request |
| soc | output | 1 | Start-of-conversion pulse |
| result_valid | output | 4 | One-hot result strobe for each channel |
| result_ts | output | 16 | Timestamp captured at start of conversion |

## Verification
The hardest case to reach from the ports is a PWM edge that arrives while a window is already open, because the restart must extend the hold-off rather than add to it. To create it, the stimulus first parks the sequencer on one channel with the extra-blank input. It then releases the extra-blank input at the same moment as the first PWM edge, sends a second edge of the opposite polarity partway through the window, and measures the exact cycle at which `soc` appears. Dropping a channel's enable while the sequencer is parked there in the same way tests the move-on path.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int unsigned NCH   = 4;
    localparam int unsigned CH_W  = $clog2(NCH);
    localparam int unsigned PH_W  = 2;
    localparam int unsigned TS_W  = 16;

    typedef logic [CH_W-1:0] ch_idx_t;
    typedef logic [PH_W-1:0] phase_t;
    typedef logic [TS_W-1:0] stamp_t;

    typedef enum logic [2:0] {
        SQ_SELECT,
        SQ_WAIT_BLANK,
        SQ_START,
        SQ_WAIT_DONE,
        SQ_ADVANCE
    } seq_state_e;

    function automatic phase_t phase_legal(input phase_t p);
        return (p > phase_t'(2)) ? phase_t'(0) : p;
    endfunction

    function automatic ch_idx_t next_ch(input ch_idx_t c);
        return (c == ch_idx_t'(NCH - 1)) ? ch_idx_t'(0) : ch_idx_t'(c + 1'b1);
    endfunction
endpackage

// File: rtl/seq_blank_timer.sv
module seq_blank_timer #(
    parameter int unsigned BLANK_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pwm_i,
    input  logic               extra_i,
    input  logic [BLANK_W-1:0] len_i,
    output logic               blanked_o
);
    logic               pwm_q;
    logic [BLANK_W-1:0] cnt_q;
    logic               edge_w;

    assign edge_w = pwm_i ^ pwm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_q <= 1'b0;
            cnt_q <= '0;
        end else begin
            pwm_q <= pwm_i;
            if (edge_w)
                cnt_q <= len_i;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign blanked_o = edge_w | (cnt_q != '0) | extra_i;

    assert_blank_restart_R4: assert property (@(posedge clk) disable iff (rst)
        edge_w |=> (cnt_q == $past(len_i)));
    assert_blank_countdown_R4: assert property (@(posedge clk) disable iff (rst)
        (!edge_w && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_stamp_counter.sv
module seq_stamp_counter
    import adcseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    output stamp_t stamp_o
);
    always_ff @(posedge clk) begin
        if (rst) stamp_o <= '0;
        else     stamp_o <= stamp_o + 1'b1;
    end

    assert_stamp_step_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (stamp_o == stamp_t'($past(stamp_o) + 1'b1)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import adcseq_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] en_i,
    input  logic [NCH-1:0] blk_i,
    input  logic           done_i,
    output ch_idx_t        cur_o,
    output logic           soc_o,
    output logic [NCH-1:0] strobe_o
);
    seq_state_e state_q, state_d;
    ch_idx_t    cur_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_SELECT:
                if (en_i[cur_q])   state_d = SQ_WAIT_BLANK;
                else if (|en_i)    state_d = SQ_ADVANCE;
            SQ_WAIT_BLANK:
                if (!en_i[cur_q])      state_d = SQ_ADVANCE;
                else if (!blk_i[cur_q]) state_d = SQ_START;
            SQ_START:     state_d = SQ_WAIT_DONE;
            SQ_WAIT_DONE: if (done_i) state_d = SQ_ADVANCE;
            SQ_ADVANCE:   state_d = SQ_SELECT;
            default:      state_d = SQ_SELECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_SELECT;
            cur_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_ADVANCE) cur_q <= next_ch(cur_q);
        end
    end

    always_comb begin
        strobe_o = '0;
        if (state_q == SQ_WAIT_DONE && done_i) strobe_o[cur_q] = 1'b1;
    end

    assign soc_o = (state_q == SQ_START);
    assign cur_o = cur_q;

    assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> (cur_q == next_ch($past(cur_q))));
    assert_idle_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_SELECT && en_i == '0) |=> !soc_o);
    assert_soc_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        soc_o |=> !soc_o);
    assert_soc_gate_R7: assert property (@(posedge clk) disable iff (rst)
        soc_o |-> $past(en_i[cur_q] && !blk_i[cur_q]));
    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));
    assert_strobe_sel_R9: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |-> strobe_o[cur_q]);
    assert_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
        soc_o |=> $stable(cur_q));
endmodule

// File: rtl/adc_rr_sequencer.sv
module adc_rr_sequencer
    import adcseq_pkg::*;
#(
    parameter int unsigned BLANK_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [BLANK_W-1:0]     blank_cycles,
    input  logic [NCH-1:0]         pwm,
    input  logic [NCH-1:0]         samp_en,
    input  logic [NCH-1:0]         extra_blank,
    input  logic [NCH*PH_W-1:0]    phase_sel,
    input  logic                   conv_done,
    output logic [CH_W-1:0]        ch_sel,
    output logic [PH_W-1:0]        phase_out,
    output logic                   soc,
    output logic [NCH-1:0]         result_valid,
    output logic [TS_W-1:0]        result_ts
);
    logic [NCH-1:0] blanked;
    stamp_t         stamps [NCH];
    stamp_t         stamp_q;
    ch_idx_t        cur;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        seq_blank_timer #(.BLANK_W(BLANK_W)) u_blank (
            .clk       (clk),
            .rst       (rst),
            .pwm_i     (pwm[g]),
            .extra_i   (extra_blank[g]),
            .len_i     (blank_cycles),
            .blanked_o (blanked[g])
        );
        seq_stamp_counter u_stamp (
            .clk     (clk),
            .rst     (rst),
            .stamp_o (stamps[g])
        );
    end

    seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en_i     (samp_en),
        .blk_i    (blanked),
        .done_i   (conv_done),
        .cur_o    (cur),
        .soc_o    (soc),
        .strobe_o (result_valid)
    );

    always_ff @(posedge clk) begin
        if (rst)      stamp_q <= '0;
        else if (soc) stamp_q <= stamps[cur];
    end

    assign ch_sel    = cur;
    assign phase_out = phase_legal(phase_sel[cur*PH_W +: PH_W]);
    assign result_ts = stamp_q;

    assert_capture_R10: assert property (@(posedge clk) disable iff (rst)
        soc |=> (result_ts == $past(stamps[cur])));
    assert_phase_legal_R8: assert property (@(posedge clk) disable iff (rst)
        phase_out != 2'd3);
endmodule

// File: tb/adc_rr_sequencer_tb.sv
module adc_rr_sequencer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] blank_cycles = 8'd20;
    logic [3:0] pwm = '0;
    logic [3:0] samp_en = '0;
    logic [3:0] extra_blank = '0;
    logic [7:0] phase_sel = 8'b10_01_00_10;
    logic       conv_done = 1'b0;
    logic [1:0] ch_sel;
    logic [1:0] phase_out;
    logic       soc;
    logic [3:0] result_valid;
    logic [15:0] result_ts;

    int checks = 0;
    int errors = 0;
    int cyc;

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    adc_rr_sequencer u_dut (
        .clk(clk), .rst(rst), .blank_cycles(blank_cycles), .pwm(pwm),
        .samp_en(samp_en), .extra_blank(extra_blank), .phase_sel(phase_sel),
        .conv_done(conv_done), .ch_sel(ch_sel), .phase_out(phase_out),
        .soc(soc), .result_valid(result_valid), .result_ts(result_ts)
    );

    // {enable mask, expected channels c3 c2 c1 c0 (c0 converted first)}
    localparam logic [11:0] VEC [6] = '{
        {4'b1111, 2'd3, 2'd2, 2'd1, 2'd0},
        {4'b1010, 2'd3, 2'd1, 2'd3, 2'd1},
        {4'b0100, 2'd2, 2'd2, 2'd2, 2'd2},
        {4'b1001, 2'd3, 2'd0, 2'd3, 2'd0},
        {4'b0110, 2'd2, 2'd1, 2'd2, 2'd1},
        {4'b1000, 2'd3, 2'd3, 2'd3, 2'd3}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic find_soc(input int maxwait, output bit got, output logic [1:0] ch,
                            output logic [1:0] ph, output int ts);
        got = 0; ch = '0; ph = '0; ts = 0;
        for (int i = 0; i < maxwait && !got; i++) begin
            @(negedge clk);
            if (soc) begin
                got = 1; ch = ch_sel; ph = phase_out; ts = cyc;
            end
        end
    endtask

    task automatic finish_conv(input logic [1:0] ch, input int ts);
        @(negedge clk);
        check(soc == 1'b0, "R7 soc single cycle", soc, 0);
        repeat (2) @(negedge clk);
        conv_done = 1'b1;
        #1;
        check(result_valid == (4'b0001 << ch), "R9 result strobe", result_valid, 4'b0001 << ch);
        check(result_ts == 16'(ts), "R10 timestamp", result_ts, ts);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit got;
        logic [1:0] ch, ph;
        int ts, t0;

        // R1 reset state
        repeat (2) @(negedge clk);
        check(ch_sel == 0 && soc == 0 && result_valid == 0, "R1 in reset", {ch_sel, soc, result_valid}, 0);
        samp_en = 4'b1111;
        rst = 1'b0;
        @(negedge clk);
        check(ch_sel == 0 && soc == 0 && result_valid == 0, "R1 after reset", {ch_sel, soc, result_valid}, 0);

        // R11 / R2 / R3 / R8 rotation table
        for (int v = 0; v < 6; v++) begin
            samp_en = VEC[v][11:8];
            do_reset();
            for (int k = 0; k < 4; k++) begin
                logic [1:0] exp_ch;
                exp_ch = VEC[v][2*k +: 2];
                find_soc(100, got, ch, ph, ts);
                check(got, "R11 conversion issued", got, 1);
                check(ch == exp_ch, "R11 R2 R3 rotation order", ch, exp_ch);
                check(ph == phase_sel[2*exp_ch +: 2], "R8 phase forward", ph, phase_sel[2*exp_ch +: 2]);
                if (got) finish_conv(ch, ts);
            end
        end

        // R3 idle with all disabled, R9 stray done ignored
        samp_en = 4'b0000;
        do_reset();
        find_soc(60, got, ch, ph, ts);
        check(!got, "R3 idle no soc", got, 0);
        conv_done = 1'b1;
        #1;
        check(result_valid == 0, "R9 stray done ignored", result_valid, 0);
        @(negedge clk);
        conv_done = 1'b0;

        // R5 extra blank holds off, then release
        samp_en = 4'b0010;
        extra_blank = 4'b0010;
        do_reset();
        find_soc(40, got, ch, ph, ts);
        check(!got, "R5 extra blank holds off", got, 0);
        extra_blank = 4'b0000;
        t0 = cyc;
        find_soc(10, got, ch, ph, ts);
        check(got && ts == t0 + 1, "R5 release latency", ts - t0, 1);
        if (got) finish_conv(ch, ts);

        // R4 rising edge opens window
        extra_blank = 4'b0010;
        repeat (15) @(negedge clk);
        pwm[1] = 1'b1;
        extra_blank = 4'b0000;
        t0 = cyc;
        find_soc(60, got, ch, ph, ts);
        check(got && ts == t0 + 22, "R4 rising edge window", ts - t0, 22);
        if (got) finish_conv(ch, ts);

        // R4 falling edge restart inside an open window
        extra_blank = 4'b0010;
        repeat (15) @(negedge clk);
        pwm[1] = 1'b0;
        extra_blank = 4'b0000;
        got = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (soc) got = 1;
        end
        pwm[1] = 1'b1;
        t0 = cyc;
        check(!got, "R4 no soc in window", got, 0);
        find_soc(60, got, ch, ph, ts);
        check(got && ts == t0 + 22, "R4 window restart", ts - t0, 22);
        if (got) finish_conv(ch, ts);

        // R6 enable dropped while parked
        extra_blank = 4'b0010;
        repeat (10) @(negedge clk);
        samp_en = 4'b0100;
        find_soc(30, got, ch, ph, ts);
        check(got && ch == 2, "R6 move on after disable", ch, 2);
        if (got) finish_conv(ch, ts);
        extra_blank = 4'b0000;

        // R8 out-of-range phase code
        phase_sel = 8'b10_11_00_10;
        find_soc(30, got, ch, ph, ts);
        check(got && ph == 0, "R8 code 3 sent as 0", ph, 0);
        if (got) finish_conv(ch, ts);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule